// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Unit

This block gives an embedded core three timers that share one time base. The time base advances on every cycle where the `tick` input is high. A fixed-interval timer raises an event whenever the time base crosses a boundary of a selectable power of two. A programmable down-counter is loaded from software, raises an event when it runs out, and then either reloads itself or stops. A watchdog runs on a second, longer selectable power-of-two period and escalates in stages. Its first expiry arms it. Its second expiry requests an interrupt. Its third expiry issues one of three reset pulses, or none.

Software sets the behaviour through a 32-bit control register, which it writes as a whole. It reads event state from a 32-bit status register, in which a bit is cleared by writing a one to it. Each interrupt request is the AND of a status bit and its enable bit in the control register. The reset outputs are single-cycle requests to reset generators outside this block.

The four period exponents are parameters. The defaults give 2^9, 2^13, 2^17 and 2^21 ticks for the fixed-interval timer and 2^17, 2^21, 2^25 and 2^29 ticks for the watchdog.

Top module: `timer_unit`

## Requirements
- R1: After a synchronous active-low reset, the control register, the status register, the programmable counter, all interrupt outputs and all reset outputs are zero. The time base restarts from zero.
- R2: Control bits 25:24 select the fixed-interval period as 2^(FIT_EXP0 + FIT_EXP_STEP*code) ticks. An event occurs on the tick that completes each such period of the time base counted from reset.
- R3: A fixed-interval event sets status bit 26. `fit_irq` is high while status bit 26 and control bit 23 are both set.
- R4: Control bits 31:30 select the watchdog period as 2^(WDT_EXP0 + WDT_EXP_STEP*code) ticks, counted on the same time base.
- R5: At a watchdog period, if status bits 31:30 are 00 or 01, status bit 31 is set.
- R6: At a watchdog period with status bits 31:30 equal to 10, status bit 30 is set. `wdog_irq` is high while status bit 30 and control bit 27 are both set.
- R7: At a watchdog period with status bits 31:30 equal to 11, control bits 29:28 are copied into status bits 29:28. The same code then requests a reset: 0 none, 1 `core_rst`, 2 `chip_rst`, 3 `sys_rst`.
- R8: Each reset output is high for exactly one cycle, in the cycle after the edge that records the stage-three expiry. At most one reset output is high at a time.
- R9: A `pit_wr` loads the programmable counter and its reload value. While running, the counter decreases by one per tick. The tick that takes it from 1 to 0 sets status bit 27. `pit_irq` is high while status bit 27 and control bit 26 are both set.
- R10: On expiry, the counter reloads its last loaded value when control bit 22 is set. Otherwise it stays at 0.
- R11: The programmable counter holds its value when the loaded value is 0 or 1, or when control bit 26 is clear.
- R12: Writing the status register clears exactly the bits written as one. An event in the same cycle wins over a clear of its bit. Set bits stay set without a clear.
- R13: `ctrl_wr` replaces the whole control register, which reads back unchanged. Status bits 25:0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base advance enable |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_mask | input | 32 | Ones clear the matching status bits |
| pit_wr | input | 1 | Programmable counter load strobe |
| pit_wdata | input | PIT_W | Programmable counter load value |
| ctrl_q | output | 32 | Control register contents |
| stat_q | output | 32 | Status register contents |
| pit_count | output | PIT_W | Programmable counter value |
| fit_irq | output | 1 | Fixed-interval interrupt request |
| pit_irq | output | 1 | Programmable timer interrupt request |
| wdog_irq | output | 1 | Watchdog interrupt request |
| core_rst | output | 1 | Core reset request pulse |
| chip_rst | output | 1 | Chip reset request pulse |
| sys_rst | output | 1 | System reset request pulse |

## Verification
The bench builds the unit with FIT_EXP0=2, FIT_EXP_STEP=1, WDT_EXP0=4 and WDT_EXP_STEP=1. With these values the fixed-interval periods are 4, 8, 16 and 32 ticks and the watchdog periods are 16, 32, 64 and 128 ticks. Every period code therefore fires many times in a short run. The watchdog reaches its third stage and every reset code within a few hundred cycles, which is impossible to reach with the default exponents. A gated tick pattern and a random phase make status clears land on the same cycle as events and make counter reloads collide with expiries.

// File: rtl/tmr_pkg.sv
// Shared constants for the timer unit: control/status bit positions,
// reset kind encoding and elaboration helpers.
// Assumes a 32-bit control and status register.
package tmr_pkg;

    // Control register fields
    localparam int CTL_WDT_PER = 30;  // 31:30 watchdog period code
    localparam int CTL_WDT_RST = 28;  // 29:28 watchdog reset kind
    localparam int CTL_WDT_IE  = 27;
    localparam int CTL_PIT_IE  = 26;  // also the run enable of the counter
    localparam int CTL_FIT_PER = 24;  // 25:24 fixed-interval period code
    localparam int CTL_FIT_IE  = 23;
    localparam int CTL_PIT_AR  = 22;

    // Status register fields
    localparam int STS_WDT_ARM = 31;
    localparam int STS_WDT_HIT = 30;
    localparam int STS_RST_LO  = 28;  // 29:28 recorded reset kind
    localparam int STS_PIT     = 27;
    localparam int STS_FIT     = 26;
    localparam logic [31:0] STS_LIVE = 32'hFC00_0000;

    typedef enum logic [1:0] {
        RST_NONE = 2'd0,
        RST_CORE = 2'd1,
        RST_CHIP = 2'd2,
        RST_SYS  = 2'd3
    } rst_kind_e;

    // Largest exponent reached by a four-code period selector
    function automatic int exp_top(input int base, input int step);
        return base + 3 * step;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tmr_period_sel.sv
// Period decoder: flags the tick on which the low EXP bits of the time base
// are all ones, i.e. the tick that completes a 2^EXP period. Four exponents
// EXP0 + k*EXP_STEP are built, one per code. Assumes EXP0 >= 1 and that the
// largest exponent does not exceed TB_W.
module tmr_period_sel #(
    parameter int EXP0     = 9,
    parameter int EXP_STEP = 4,
    parameter int TB_W     = 21
) (
    input  logic            tick,
    input  logic [TB_W-1:0] tb,
    input  logic [1:0]      code,
    output logic            evt
);

    logic [3:0] hit;

    // One all-ones compare per period code
    for (genvar k = 0; k < 4; k++) begin : g_code
        localparam int EXP_K = EXP0 + EXP_STEP * k;
        localparam logic [TB_W-1:0] MASK_K = TB_W'((64'd1 << EXP_K) - 64'd1);
        assign hit[k] = ((tb & MASK_K) == MASK_K);
    end

    assign evt = tick & hit[code];

endmodule

// File: rtl/tmr_timebase.sv
// Shared time base with the two period decoders. The counter advances on
// tick and wraps at 2^TB_W, where TB_W is the largest exponent in use, so
// every selectable period divides the wrap.
module tmr_timebase #(
    parameter int FIT_EXP0     = 9,
    parameter int FIT_EXP_STEP = 4,
    parameter int WDT_EXP0     = 17,
    parameter int WDT_EXP_STEP = 4,
    parameter int TB_W         = 29
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] fit_code,
    input  logic [1:0] wdt_code,
    output logic       fit_evt,
    output logic       wdt_evt
);

    logic [TB_W-1:0] tb;

    // Time base counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            tb <= '0;
        else if (tick)
            tb <= tb + TB_W'(1);
    end

    tmr_period_sel #(
        .EXP0(FIT_EXP0), .EXP_STEP(FIT_EXP_STEP), .TB_W(TB_W)
    ) u_fit_sel (
        .tick(tick), .tb(tb), .code(fit_code), .evt(fit_evt)
    );

    tmr_period_sel #(
        .EXP0(WDT_EXP0), .EXP_STEP(WDT_EXP_STEP), .TB_W(TB_W)
    ) u_wdt_sel (
        .tick(tick), .tb(tb), .code(wdt_code), .evt(wdt_evt)
    );

endmodule

// File: rtl/tmr_pit.sv
// Programmable down-counter. A load sets both the count and the reload
// value. It runs only while enabled, with a reload value above one and a
// nonzero count. The expiry flag is combinational, for the tick that takes
// the count from 1 to 0. A load wins over counting in the same cycle.
module tmr_pit #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          en,
    input  logic          auto_rl,
    output logic [CW-1:0] count,
    output logic          expire
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] rel;
    logic          running;

    // Run qualification and expiry detect
    always_comb begin
        running = en && (rel > CW'(1)) && (cnt != '0);
        expire  = tick && running && (cnt == CW'(1)) && !load;
    end

    // Count, reload value and load handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            rel <= '0;
        end else if (load) begin
            cnt <= load_val;
            rel <= load_val;
        end else if (tick && running) begin
            if (cnt == CW'(1))
                cnt <= auto_rl ? rel : '0;
            else
                cnt <= cnt - CW'(1);
        end
    end

    assign count = cnt;

endmodule

// File: rtl/tmr_wdog.sv
// Watchdog stage logic. From the current stage (status bits 31:30) it picks
// the action at a period event: arm, raise interrupt, or record the reset
// kind and issue one registered single-cycle reset pulse.
module tmr_wdog
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt,
    input  logic [1:0] stage,
    input  logic [1:0] rst_code,
    output logic       set_arm,
    output logic       set_hit,
    output logic       latch_code,
    output logic       core_pulse,
    output logic       chip_pulse,
    output logic       sys_pulse
);

    rst_kind_e kind;

    // Stage decode at a period event
    always_comb begin
        kind       = rst_kind_e'(rst_code);
        set_arm    = evt && !stage[1];
        set_hit    = evt && (stage == 2'b10);
        latch_code = evt && (stage == 2'b11);
    end

    // Registered reset request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_pulse <= 1'b0;
            chip_pulse <= 1'b0;
            sys_pulse  <= 1'b0;
        end else begin
            core_pulse <= latch_code && (kind == RST_CORE);
            chip_pulse <= latch_code && (kind == RST_CHIP);
            sys_pulse  <= latch_code && (kind == RST_SYS);
        end
    end

endmodule

// File: rtl/timer_unit.sv
// Timer unit top: control register, write-one-to-clear status register,
// shared time base, programmable counter and watchdog. Events use the
// control value held before a same-cycle control write. Status clears apply
// before new events, so an event wins over a clear of its own bit.
module timer_unit
    import tmr_pkg::*;
#(
    parameter int FIT_EXP0     = 9,
    parameter int FIT_EXP_STEP = 4,
    parameter int WDT_EXP0     = 17,
    parameter int WDT_EXP_STEP = 4,
    parameter int PIT_W        = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic [31:0]      ctrl_wdata,
    input  logic             stat_clr_wr,
    input  logic [31:0]      stat_clr_mask,
    input  logic             pit_wr,
    input  logic [PIT_W-1:0] pit_wdata,
    output logic [31:0]      ctrl_q,
    output logic [31:0]      stat_q,
    output logic [PIT_W-1:0] pit_count,
    output logic             fit_irq,
    output logic             pit_irq,
    output logic             wdog_irq,
    output logic             core_rst,
    output logic             chip_rst,
    output logic             sys_rst
);

    localparam int TB_W = imax(exp_top(FIT_EXP0, FIT_EXP_STEP),
                               exp_top(WDT_EXP0, WDT_EXP_STEP));

    logic [31:0] ctrl_r;
    logic [31:0] stat_r;
    logic [31:0] stat_nx;
    logic        fit_evt;
    logic        wdt_evt;
    logic        pit_exp;
    logic        wd_arm;
    logic        wd_hit;
    logic        wd_latch;

    tmr_timebase #(
        .FIT_EXP0(FIT_EXP0), .FIT_EXP_STEP(FIT_EXP_STEP),
        .WDT_EXP0(WDT_EXP0), .WDT_EXP_STEP(WDT_EXP_STEP),
        .TB_W(TB_W)
    ) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .fit_code(ctrl_r[CTL_FIT_PER +: 2]),
        .wdt_code(ctrl_r[CTL_WDT_PER +: 2]),
        .fit_evt(fit_evt), .wdt_evt(wdt_evt)
    );

    tmr_pit #(.CW(PIT_W)) u_pit (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(pit_wr), .load_val(pit_wdata),
        .en(ctrl_r[CTL_PIT_IE]), .auto_rl(ctrl_r[CTL_PIT_AR]),
        .count(pit_count), .expire(pit_exp)
    );

    tmr_wdog u_wdog (
        .clk(clk), .rst_n(rst_n), .evt(wdt_evt),
        .stage(stat_r[STS_WDT_HIT +: 2]),
        .rst_code(ctrl_r[CTL_WDT_RST +: 2]),
        .set_arm(wd_arm), .set_hit(wd_hit), .latch_code(wd_latch),
        .core_pulse(core_rst), .chip_pulse(chip_rst), .sys_pulse(sys_rst)
    );

    // Control register, whole-word write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_r <= '0;
        else if (ctrl_wr)
            ctrl_r <= ctrl_wdata;
    end

    // Next status: clear first, then recorded kind, then new events
    always_comb begin
        stat_nx = stat_r;
        if (stat_clr_wr)
            stat_nx = stat_nx & ~stat_clr_mask;
        if (wd_latch)
            stat_nx[STS_RST_LO +: 2] = ctrl_r[CTL_WDT_RST +: 2];
        if (wd_arm)
            stat_nx[STS_WDT_ARM] = 1'b1;
        if (wd_hit)
            stat_nx[STS_WDT_HIT] = 1'b1;
        if (pit_exp)
            stat_nx[STS_PIT] = 1'b1;
        if (fit_evt)
            stat_nx[STS_FIT] = 1'b1;
        stat_nx = stat_nx & STS_LIVE;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_r <= '0;
        else
            stat_r <= stat_nx;
    end

    // Interrupt requests gated by their enables
    always_comb begin
        fit_irq  = stat_r[STS_FIT] & ctrl_r[CTL_FIT_IE];
        pit_irq  = stat_r[STS_PIT] & ctrl_r[CTL_PIT_IE];
        wdog_irq = stat_r[STS_WDT_HIT] & ctrl_r[CTL_WDT_IE];
    end

    assign ctrl_q = ctrl_r;
    assign stat_q = stat_r;

endmodule

// File: rtl/timer_unit_chk.sv
// Property checker for timer_unit, attached by bind. It observes only the
// top-level ports.
module timer_unit_chk #(
    parameter int PIT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stat_clr_wr,
    input logic             pit_wr,
    input logic [31:0]      ctrl_q,
    input logic [31:0]      stat_q,
    input logic [PIT_W-1:0] pit_count,
    input logic             core_rst,
    input logic             chip_rst,
    input logic             sys_rst
);

    localparam logic [31:0] STICKY = 32'hCC00_0000;

    p_rst_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_rst, chip_rst, sys_rst}));

    p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst || chip_rst || sys_rst) |=> !(core_rst || chip_rst || sys_rst));

    p_core_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> ($past(ctrl_q[29:28]) == 2'd1 && $past(stat_q[31:30]) == 2'b11));

    p_chip_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |-> ($past(ctrl_q[29:28]) == 2'd2 && $past(stat_q[31:30]) == 2'b11));

    p_sys_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> ($past(ctrl_q[29:28]) == 2'd3 && $past(stat_q[31:30]) == 2'b11));

    p_hit_after_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[30]) |-> $past(stat_q[31]));

    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr_wr |=> ((stat_q & $past(stat_q) & STICKY) == ($past(stat_q) & STICKY)));

    p_pit_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pit_wr && !ctrl_q[26]) |=> $stable(pit_count));

    p_pit_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pit_wr && pit_count == '0) |=> (pit_count == '0));

endmodule

bind timer_unit timer_unit_chk #(.PIT_W(PIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stat_clr_wr(stat_clr_wr), .pit_wr(pit_wr),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .pit_count(pit_count),
    .core_rst(core_rst), .chip_rst(chip_rst), .sys_rst(sys_rst)
);

// File: tb/timer_unit_tb.sv
// Bench: behavioural reference model stepped once per clock, compared with
// every output after each edge.
module timer_unit_tb;

    localparam int FE0 = 2;
    localparam int FES = 1;
    localparam int WE0 = 4;
    localparam int WES = 1;
    localparam int TB_MOD = 128;  // 2^(WE0 + 3*WES)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        stat_clr_wr = 1'b0;
    logic [31:0] stat_clr_mask = '0;
    logic        pit_wr = 1'b0;
    logic [31:0] pit_wdata = '0;
    logic [31:0] ctrl_q, stat_q, pit_count;
    logic        fit_irq, pit_irq, wdog_irq, core_rst, chip_rst, sys_rst;

    always #5 clk = ~clk;

    timer_unit #(
        .FIT_EXP0(FE0), .FIT_EXP_STEP(FES),
        .WDT_EXP0(WE0), .WDT_EXP_STEP(WES), .PIT_W(32)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .stat_clr_wr(stat_clr_wr), .stat_clr_mask(stat_clr_mask),
        .pit_wr(pit_wr), .pit_wdata(pit_wdata),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .pit_count(pit_count),
        .fit_irq(fit_irq), .pit_irq(pit_irq), .wdog_irq(wdog_irq),
        .core_rst(core_rst), .chip_rst(chip_rst), .sys_rst(sys_rst)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state
    int          m_tb = 0;
    logic [31:0] m_ctrl = '0, m_stat = '0, m_cnt = '0, m_rel = '0;
    logic        m_core = 0, m_chip = 0, m_sys = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance the model by one clock using the inputs about to be sampled
    task automatic model_step();
        logic [31:0] s;
        int fexp, wexp;
        bit fevt, wevt, pexp;
        if (!rst_n) begin
            m_tb = 0; m_ctrl = '0; m_stat = '0; m_cnt = '0; m_rel = '0;
            m_core = 0; m_chip = 0; m_sys = 0;
            return;
        end
        fexp = FE0 + FES * int'(m_ctrl[25:24]);
        wexp = WE0 + WES * int'(m_ctrl[31:30]);
        fevt = tick && (((m_tb + 1) % (1 << fexp)) == 0);
        wevt = tick && (((m_tb + 1) % (1 << wexp)) == 0);
        pexp = 0;
        s = m_stat;
        if (stat_clr_wr) s = s & ~stat_clr_mask;
        m_core = 0; m_chip = 0; m_sys = 0;
        if (wevt) begin
            case (m_stat[31:30])
                2'b00, 2'b01: s[31] = 1'b1;
                2'b10: s[30] = 1'b1;
                default: begin
                    s[29:28] = m_ctrl[29:28];
                    m_core = (m_ctrl[29:28] == 2'd1);
                    m_chip = (m_ctrl[29:28] == 2'd2);
                    m_sys  = (m_ctrl[29:28] == 2'd3);
                end
            endcase
        end
        if (pit_wr) begin
            m_cnt = pit_wdata; m_rel = pit_wdata;
        end else if (tick && m_ctrl[26] && m_rel > 1 && m_cnt != 0) begin
            if (m_cnt == 1) begin
                pexp = 1;
                m_cnt = m_ctrl[22] ? m_rel : 32'd0;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        if (pexp) s[27] = 1'b1;
        if (fevt) s[26] = 1'b1;
        m_stat = s & 32'hFC00_0000;
        if (ctrl_wr) m_ctrl = ctrl_wdata;
        if (tick) m_tb = (m_tb + 1) % TB_MOD;
    endtask

    task automatic compare_all();
        chk("R13 ctrl_q", ctrl_q, m_ctrl);
        chk("R12/R13 stat_q", stat_q, m_stat);
        chk("R2/R3 fit status", {31'd0, stat_q[26]}, {31'd0, m_stat[26]});
        chk("R4/R5 wdog arm status", {31'd0, stat_q[31]}, {31'd0, m_stat[31]});
        chk("R6 wdog hit status", {31'd0, stat_q[30]}, {31'd0, m_stat[30]});
        chk("R7 recorded kind", {30'd0, stat_q[29:28]}, {30'd0, m_stat[29:28]});
        chk("R9/R10/R11 pit_count", pit_count, m_cnt);
        chk("R3 fit_irq", {31'd0, fit_irq}, {31'd0, m_stat[26] & m_ctrl[23]});
        chk("R9 pit_irq", {31'd0, pit_irq}, {31'd0, m_stat[27] & m_ctrl[26]});
        chk("R6 wdog_irq", {31'd0, wdog_irq}, {31'd0, m_stat[30] & m_ctrl[27]});
        chk("R7/R8 reset pulses", {29'd0, core_rst, chip_rst, sys_rst},
            {29'd0, m_core, m_chip, m_sys});
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        #2;
        compare_all();
        ctrl_wr = 0; stat_clr_wr = 0; pit_wr = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        ctrl_wr = 1; ctrl_wdata = v; cycle();
    endtask

    task automatic clr_stat(input logic [31:0] v);
        stat_clr_wr = 1; stat_clr_mask = v; cycle();
    endtask

    task automatic load_pit(input logic [31:0] v);
        pit_wr = 1; pit_wdata = v; cycle();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(7));
        rst_n = 0; tick = 1;
        run(3);
        // R1: reset state at the ports
        chk("R1 ctrl after reset", ctrl_q, 32'd0);
        chk("R1 stat after reset", stat_q, 32'd0);
        chk("R1 pit after reset", pit_count, 32'd0);
        chk("R1 outputs after reset",
            {26'd0, fit_irq, pit_irq, wdog_irq, core_rst, chip_rst, sys_rst}, 32'd0);
        rst_n = 1;
        run(2);

        // R2/R3: fixed interval, shortest code with interrupt enabled
        wr_ctrl(32'h0080_0000);
        run(30);
        clr_stat(32'h0400_0000);
        // R2: longest fixed-interval code under a gated tick
        wr_ctrl(32'h0380_0000);
        for (int i = 0; i < 90; i++) begin
            tick = (i % 3) != 0;
            cycle();
        end
        tick = 1;
        clr_stat(32'hFFFF_FFFF);

        // R9/R10: one-shot then auto-reload
        wr_ctrl(32'h0400_0000);
        load_pit(32'd5);
        run(10);
        clr_stat(32'h0800_0000);
        wr_ctrl(32'h0440_0000);
        load_pit(32'd3);
        run(15);
        // R11: loaded 1 and 0 hold, disabled counter holds
        load_pit(32'd1);
        run(5);
        load_pit(32'd0);
        run(5);
        wr_ctrl(32'h0000_0000);
        load_pit(32'd7);
        run(6);
        clr_stat(32'hFFFF_FFFF);

        // R4..R8: watchdog escalation for every reset kind
        wr_ctrl(32'h2800_0000);
        clr_stat(32'hFFFF_FFFF);
        run(70);
        wr_ctrl(32'h3800_0000);
        run(40);
        wr_ctrl(32'h1800_0000);
        run(40);
        wr_ctrl(32'h0800_0000);
        run(40);
        clr_stat(32'hFFFF_FFFF);
        wr_ctrl(32'h7800_0000);
        run(200);
        clr_stat(32'h4000_0000);
        run(40);

        // Random phase: collisions of clears, loads and events
        for (int i = 0; i < 3000; i++) begin
            tick = ($urandom % 4) != 0;
            if ($urandom % 50 == 0) begin
                ctrl_wr = 1; ctrl_wdata = $urandom;
            end
            if ($urandom % 30 == 0) begin
                stat_clr_wr = 1; stat_clr_mask = $urandom;
            end
            if ($urandom % 40 == 0) begin
                pit_wr = 1; pit_wdata = $urandom % 12;
            end
            cycle();
        end

        // R1: mid-run reset returns everything to zero
        rst_n = 0;
        run(2);
        rst_n = 1;
        run(3);

        done = 1;
        finish_run();
    end

endmodule